// File: doc/BRIEF.md
# Reservation-Table Issue Hazard Checker

This block sits at the issue point of a floating-point pipeline. Each cycle it looks at one pending instruction, which carries a class (add, multiply or convert), up to two source register tags and a destination tag. It then decides whether that instruction may start in the current cycle. The grant is returned on a registered output. On the same edge the block records the resources and the destination register of each accepted instruction.

The block keeps two structures. The first is a sliding window of future resource use. It holds one usage count per shared unit (fetch, register read, unpack, shifter, adder, rounder, register write, multiplier) for each of the next cycles. A candidate fits only if, in every future cycle, its own step pattern added to the counts already booked stays within the number of copies of that unit. The second is a per-register countdown scoreboard. It tells, for every register, how many cycles remain until a consumer may start. There are two countdowns: one for a consumer that reads the register file, and one for an add that takes the value over the bypass path into its shift/add step. When a grant relied on the bypass, a registered per-source select tells the datapath to feed the shifter and adder from that path.

Top module: `iss_hazard_chk`

## Requirements
- R1: After a synchronous reset, `grant` and `byp_sel` are low. The reservation window and the scoreboard are empty, so an instruction that depends on a register written just before the reset is granted in the first cycle after it.
- R2: A request is granted only when `req_vld` is high. Class codes are 0 = add, 1 = multiply, 2 = convert, and code 3 is never granted. The result of a request presented before a clock edge appears on `grant` right after that edge.
- R3: Each class books one fixed step pattern, one step per cycle. Add: fetch; read; unpack; shifter+adder; adder+rounder; rounder+shifter; write. Multiply: fetch; read; unpack; four multiplier steps; adder; rounder; write. Convert: fetch; read; unpack; shifter; rounder; write. With nothing in flight, any valid class is granted.
- R4: With one copy of each unit, an add is refused 3 or 4 cycles after a granted multiply, and 1 cycle after a granted add.
- R5: Usage is summed over all booked instructions per cycle and per unit, and compared with that unit's copy count. With two adders and two rounders, an add is granted 4 cycles and also 1 cycle after a multiply or add. It is still refused 3 cycles after a multiply, because of the single write port.
- R6: The multiplier is one unit occupied for four consecutive steps, so a second multiply 1 cycle after a granted multiply is refused. A convert 2 cycles after a multiply is granted.
- R7: Without the bypass, a consumer of register r may start no earlier than W cycles after r's producer started. W is the producer's write step: 6 for add, 9 for multiply, 5 for convert.
- R8: With the bypass built in, an add consumer may start when its shift/add step (step 3) directly follows the producer's last rounder step. That is 6 cycles after a multiply and 3 after an add. `byp_sel` bit 0 (source A) or bit 1 (source B) is then high together with `grant`, and only when that source is still waiting for write-back.
- R9: The bypass serves only add consumers. A convert that reads a multiply result 6 cycles after it is refused.
- R10: A source whose use flag is low never holds a request. A destination whose use flag is low books no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_vld | input | 1 | A candidate instruction is present |
| req_cls | input | 2 | Candidate class: 0 add, 1 multiply, 2 convert, 3 none |
| src_a | input | $clog2(NREG) | First source register tag |
| src_a_use | input | 1 | First source is read |
| src_b | input | $clog2(NREG) | Second source register tag |
| src_b_use | input | 1 | Second source is read |
| dst | input | $clog2(NREG) | Destination register tag |
| dst_use | input | 1 | Destination is written |
| grant | output | 1 | Candidate presented before the last edge was accepted |
| byp_sel | output | 2 | Per source (bit 0 = A, bit 1 = B): take operand from the bypass into shifter and adder |

## Verification
The bench drives two copies side by side from the same inputs. One uses the default build: a single copy of every unit, with the bypass enabled. The other has two adders and two rounders, with the bypass removed. The single-copy build covers the pairwise refusal offsets and the bypass timings with their select bits. The doubled build covers summed counting, where an add may enter 1 and 4 cycles behind earlier work, and the full write-back wait without the bypass. Because the two builds see one stimulus but must give different answers at the same cycles, each offset is tested on both sides of its boundary.

// File: rtl/iss_pkg.sv
package iss_pkg;

  localparam int NRES    = 8;
  localparam int MAX_STG = 10;

  // resource slots of the reservation window
  localparam int RS_FETCH = 0;
  localparam int RS_READ  = 1;
  localparam int RS_UNPK  = 2;
  localparam int RS_SHF   = 3;
  localparam int RS_ADD   = 4;
  localparam int RS_RND   = 5;
  localparam int RS_WR    = 6;
  localparam int RS_MUL   = 7;

  localparam logic [1:0] CL_ADD  = 2'd0;
  localparam logic [1:0] CL_MUL  = 2'd1;
  localparam logic [1:0] CL_CONV = 2'd2;
  localparam logic [1:0] CL_NONE = 2'd3;

  typedef logic [NRES-1:0] rmask_t;

  function automatic rmask_t one_res(input int r);
    rmask_t m;
    m    = '0;
    m[r] = 1'b1;
    return m;
  endfunction

  // units used by step stg of a class (one step per cycle after start)
  function automatic rmask_t stage_use(input logic [1:0] cls, input int stg);
    rmask_t m;
    m = '0;
    if (stg == 0)      m = one_res(RS_FETCH);
    else if (stg == 1) m = one_res(RS_READ);
    else if (stg == 2) m = one_res(RS_UNPK);
    else begin
      case (cls)
        CL_ADD: case (stg)
          3:       m = one_res(RS_SHF) | one_res(RS_ADD);
          4:       m = one_res(RS_ADD) | one_res(RS_RND);
          5:       m = one_res(RS_RND) | one_res(RS_SHF);
          6:       m = one_res(RS_WR);
          default: m = '0;
        endcase
        CL_MUL: case (stg)
          3, 4, 5, 6: m = one_res(RS_MUL);
          7:          m = one_res(RS_ADD);
          8:          m = one_res(RS_RND);
          9:          m = one_res(RS_WR);
          default:    m = '0;
        endcase
        CL_CONV: case (stg)
          3:       m = one_res(RS_SHF);
          4:       m = one_res(RS_RND);
          5:       m = one_res(RS_WR);
          default: m = '0;
        endcase
        default: m = '0;
      endcase
    end
    if (cls == CL_NONE) m = '0;
    return m;
  endfunction

  function automatic int last_use(input logic [1:0] cls, input int r);
    int s;
    rmask_t m;
    s = 0;
    for (int i = 0; i < MAX_STG; i++) begin
      m = stage_use(cls, i);
      if (m[r]) s = i;
    end
    return s;
  endfunction

  function automatic int first_use(input logic [1:0] cls, input int r);
    int s;
    rmask_t m;
    s = MAX_STG;
    for (int i = MAX_STG - 1; i >= 0; i--) begin
      m = stage_use(cls, i);
      if (m[r]) s = i;
    end
    return s;
  endfunction

  // start distance for a consumer that reads the register file
  function automatic int wb_wait(input logic [1:0] cls);
    return last_use(cls, RS_WR);
  endfunction

  // start distance for an add consumer fed from the rounder output
  function automatic int byp_wait(input logic [1:0] cls);
    return last_use(cls, RS_RND) + 1 - first_use(CL_ADD, RS_ADD);
  endfunction

endpackage

// File: rtl/iss_resv_window.sv
module iss_resv_window
  import iss_pkg::*;
#(
  parameter int DEPTH = MAX_STG,
  parameter int CW    = 2,
  parameter logic [NRES*CW-1:0] COPY_V = '0
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] cls,
  input  logic       take,
  output logic       fit
);

  // win[k][r]: copies of unit r booked for the cycle k ahead (k = 0 is now)
  logic [CW-1:0] win    [DEPTH][NRES];
  logic [CW-1:0] win_nx [DEPTH][NRES];
  logic          over;

  always_comb begin
    fit = 1'b1;
    for (int j = 0; j < DEPTH; j++) begin
      rmask_t u;
      u = stage_use(cls, j);
      for (int r = 0; r < NRES; r++) begin
        if (({1'b0, win[j][r]} + {{CW{1'b0}}, u[r]}) > {1'b0, COPY_V[r*CW +: CW]})
          fit = 1'b0;
      end
    end
  end

  // shift by one slot per clock; a granted candidate books its steps 1..
  always_comb begin
    for (int k = 0; k < DEPTH - 1; k++) begin
      rmask_t nu;
      nu = stage_use(cls, k + 1);
      for (int r = 0; r < NRES; r++)
        win_nx[k][r] = win[k+1][r] + {{(CW-1){1'b0}}, take & nu[r]};
    end
    for (int r = 0; r < NRES; r++) win_nx[DEPTH-1][r] = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < DEPTH; k++)
        for (int r = 0; r < NRES; r++) win[k][r] <= '0;
    end else begin
      win <= win_nx;
    end
  end

  always_comb begin
    over = 1'b0;
    for (int k = 0; k < DEPTH; k++)
      for (int r = 0; r < NRES; r++)
        if (win[k][r] > COPY_V[r*CW +: CW]) over = 1'b1;
  end

  // R5
  win_cap_chk: assert property (@(posedge clk) disable iff (rst) !over);

  // R4
  take_fit_chk: assert property (@(posedge clk) disable iff (rst) take |-> fit);

endmodule

// File: rtl/iss_scoreboard.sv
module iss_scoreboard #(
  parameter int NREG = 32,
  parameter int TW   = 4,
  localparam int RW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [RW-1:0] sa,
  input  logic          sa_use,
  input  logic [RW-1:0] sb,
  input  logic          sb_use,
  input  logic [RW-1:0] dst,
  input  logic          dst_use,
  input  logic          take,
  input  logic [TW-1:0] wb_set,
  input  logic [TW-1:0] byp_set,
  input  logic          byp_ok,
  output logic          deps_ok,
  output logic          via_a,
  output logic          via_b
);

  // cycles left until a consumer may start (0 = ready)
  logic [TW-1:0] rem_wb     [NREG];
  logic [TW-1:0] rem_byp    [NREG];
  logic [TW-1:0] rem_wb_nx  [NREG];
  logic [TW-1:0] rem_byp_nx [NREG];
  logic a_wb, a_by, b_wb, b_by;

  always_comb begin
    a_wb    = (rem_wb[sa] == '0);
    a_by    = byp_ok && (rem_byp[sa] == '0);
    b_wb    = (rem_wb[sb] == '0);
    b_by    = byp_ok && (rem_byp[sb] == '0);
    via_a   = sa_use && !a_wb && a_by;
    via_b   = sb_use && !b_wb && b_by;
    deps_ok = (!sa_use || a_wb || a_by) && (!sb_use || b_wb || b_by);
  end

  always_comb begin
    for (int i = 0; i < NREG; i++) begin
      logic [TW-1:0] dw, db;
      dw = (rem_wb[i]  == '0) ? '0 : rem_wb[i]  - 1'b1;
      db = (rem_byp[i] == '0) ? '0 : rem_byp[i] - 1'b1;
      if (take && dst_use && (dst == RW'(i))) begin
        dw = (dw > wb_set)  ? dw : wb_set;
        db = (db > byp_set) ? db : byp_set;
      end
      rem_wb_nx[i]  = dw;
      rem_byp_nx[i] = db;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) begin
        rem_wb[i]  <= '0;
        rem_byp[i] <= '0;
      end
    end else begin
      rem_wb  <= rem_wb_nx;
      rem_byp <= rem_byp_nx;
    end
  end

  for (genvar i = 0; i < NREG; i++) begin : g_reg_chk
    // R8
    byp_order_chk: assert property (@(posedge clk) disable iff (rst)
      rem_byp[i] <= rem_wb[i]);
  end

  // R7
  dst_pend_chk: assert property (@(posedge clk) disable iff (rst)
    (take && dst_use && wb_set != '0) |=> (rem_wb[$past(dst)] != '0));

endmodule

// File: rtl/iss_hazard_chk.sv
module iss_hazard_chk
  import iss_pkg::*;
#(
  parameter int unsigned NREG      = 32,
  parameter int unsigned N_FETCH   = 1,
  parameter int unsigned N_READ    = 1,
  parameter int unsigned N_UNPACK  = 1,
  parameter int unsigned N_SHIFTER = 1,
  parameter int unsigned N_ADDER   = 1,
  parameter int unsigned N_ROUNDER = 1,
  parameter int unsigned N_WRITE   = 1,
  parameter int unsigned N_MULT    = 1,
  parameter bit          BYPASS_EN = 1'b1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    req_vld,
  input  logic [1:0]              req_cls,
  input  logic [$clog2(NREG)-1:0] src_a,
  input  logic                    src_a_use,
  input  logic [$clog2(NREG)-1:0] src_b,
  input  logic                    src_b_use,
  input  logic [$clog2(NREG)-1:0] dst,
  input  logic                    dst_use,
  output logic                    grant,
  output logic [1:0]              byp_sel
);

  localparam int DEPTH = MAX_STG;
  localparam int TW    = $clog2(DEPTH + 1);
  localparam int CW    = $clog2(N_FETCH + N_READ + N_UNPACK + N_SHIFTER +
                                N_ADDER + N_ROUNDER + N_WRITE + N_MULT + 1);
  localparam logic [NRES*CW-1:0] COPY_V = {
    CW'(N_MULT), CW'(N_WRITE), CW'(N_ROUNDER), CW'(N_ADDER),
    CW'(N_SHIFTER), CW'(N_UNPACK), CW'(N_READ), CW'(N_FETCH)};

  // countdown loads: one less than the start distance, as it decrements next cycle
  localparam logic [TW-1:0] WB_ADD  = TW'(wb_wait(CL_ADD) - 1);
  localparam logic [TW-1:0] WB_MUL  = TW'(wb_wait(CL_MUL) - 1);
  localparam logic [TW-1:0] WB_CONV = TW'(wb_wait(CL_CONV) - 1);
  localparam logic [TW-1:0] BY_ADD  = TW'(byp_wait(CL_ADD) - 1);
  localparam logic [TW-1:0] BY_MUL  = TW'(byp_wait(CL_MUL) - 1);
  localparam logic [TW-1:0] BY_CONV = TW'(byp_wait(CL_CONV) - 1);

  logic          fit, deps_ok, via_a, via_b, take;
  logic [TW-1:0] wb_set, byp_set;

  always_comb begin
    case (req_cls)
      CL_ADD:  begin wb_set = WB_ADD;  byp_set = BY_ADD;  end
      CL_MUL:  begin wb_set = WB_MUL;  byp_set = BY_MUL;  end
      CL_CONV: begin wb_set = WB_CONV; byp_set = BY_CONV; end
      default: begin wb_set = '0;      byp_set = '0;      end
    endcase
  end

  assign take = req_vld && (req_cls != CL_NONE) && fit && deps_ok;

  iss_resv_window #(
    .DEPTH (DEPTH),
    .CW    (CW),
    .COPY_V(COPY_V)
  ) u_win (
    .clk (clk),
    .rst (rst),
    .cls (req_cls),
    .take(take),
    .fit (fit)
  );

  iss_scoreboard #(
    .NREG(NREG),
    .TW  (TW)
  ) u_sb (
    .clk    (clk),
    .rst    (rst),
    .sa     (src_a),
    .sa_use (src_a_use),
    .sb     (src_b),
    .sb_use (src_b_use),
    .dst    (dst),
    .dst_use(dst_use),
    .take   (take),
    .wb_set (wb_set),
    .byp_set(byp_set),
    .byp_ok (BYPASS_EN && (req_cls == CL_ADD)),
    .deps_ok(deps_ok),
    .via_a  (via_a),
    .via_b  (via_b)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      grant   <= 1'b0;
      byp_sel <= 2'b00;
    end else begin
      grant   <= take;
      byp_sel <= take ? {via_b, via_a} : 2'b00;
    end
  end

  // R2
  no_req_chk: assert property (@(posedge clk) disable iff (rst)
    !req_vld |=> !grant);

  // R2
  bad_cls_chk: assert property (@(posedge clk) disable iff (rst)
    (req_vld && req_cls == CL_NONE) |=> !grant);

  // R8
  byp_grant_chk: assert property (@(posedge clk) disable iff (rst)
    (byp_sel != 2'b00) |-> grant);

  // R9
  byp_cls_chk: assert property (@(posedge clk) disable iff (rst)
    (req_vld && req_cls != CL_ADD) |=> (byp_sel == 2'b00));

  if (!BYPASS_EN) begin : g_nobyp
    // R8
    byp_off_chk: assert property (@(posedge clk) disable iff (rst)
      byp_sel == 2'b00);
  end

endmodule

// File: tb/sim_iss_hazard_chk.sv
module sim_iss_hazard_chk;
  import iss_pkg::*;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       req_vld = 1'b0;
  logic [1:0] req_cls = 2'd0;
  logic [4:0] src_a = '0, src_b = '0, dst = '0;
  logic       src_a_use = 1'b0, src_b_use = 1'b0, dst_use = 1'b0;
  logic       grant0, grant1;
  logic [1:0] byp0, byp1;
  int         checks = 0;
  int         errors = 0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  // single copies, bypass on
  iss_hazard_chk u0 (
    .clk(clk), .rst(rst), .req_vld(req_vld), .req_cls(req_cls),
    .src_a(src_a), .src_a_use(src_a_use), .src_b(src_b), .src_b_use(src_b_use),
    .dst(dst), .dst_use(dst_use), .grant(grant0), .byp_sel(byp0));

  // two adders, two rounders, bypass off
  iss_hazard_chk #(.N_ADDER(2), .N_ROUNDER(2), .BYPASS_EN(1'b0)) u1 (
    .clk(clk), .rst(rst), .req_vld(req_vld), .req_cls(req_cls),
    .src_a(src_a), .src_a_use(src_a_use), .src_b(src_b), .src_b_use(src_b_use),
    .dst(dst), .dst_use(dst_use), .grant(grant1), .byp_sel(byp1));

  typedef struct packed {
    logic [3:0] gap;
    logic       vld;
    logic [1:0] cls;
    logic [4:0] sa;
    logic       sau;
    logic [4:0] sb;
    logic       sbu;
    logic [4:0] d;
    logic       du;
    logic       g0;
    logic       g1;
    logic [1:0] b0;
    logic [1:0] b1;
    logic [3:0] req;
  } vec_t;

  function automatic vec_t mk(int gap, int vld, int cls, int sa, int sau, int sb,
                              int sbu, int d, int du, int g0, int g1, int b0,
                              int b1, int req);
    vec_t v;
    v.gap = 4'(gap); v.vld = 1'(vld); v.cls = 2'(cls);
    v.sa = 5'(sa); v.sau = 1'(sau); v.sb = 5'(sb); v.sbu = 1'(sbu);
    v.d = 5'(d); v.du = 1'(du); v.g0 = 1'(g0); v.g1 = 1'(g1);
    v.b0 = 2'(b0); v.b1 = 2'(b1); v.req = 4'(req);
    return v;
  endfunction

  localparam int NV = 25;
  // gap, vld, cls, sa, sau, sb, sbu, d, du, g0, g1, b0, b1, req
  localparam vec_t TBL [NV] = '{
    mk(12,1,1, 0,0, 0,0, 0,0, 1,1, 0,0,  3), // R3 multiply at t
    mk( 2,1,0, 0,0, 0,0, 0,0, 0,0, 0,0,  4), // R4 add at t+3 (write clash in both)
    mk( 0,1,0, 0,0, 0,0, 0,0, 0,1, 0,0,  5), // R5 add at t+4: only doubled build
    mk(12,1,0, 0,0, 0,0, 0,0, 1,1, 0,0,  3), // R3 add alone
    mk( 0,1,0, 0,0, 0,0, 0,0, 0,1, 0,0,  5), // R5 add behind add by 1
    mk(12,1,1, 0,0, 0,0, 0,0, 1,1, 0,0,  3), // R3 multiply
    mk( 0,1,1, 0,0, 0,0, 0,0, 0,0, 0,0,  6), // R6 second multiply refused
    mk( 0,1,2, 0,0, 0,0, 0,0, 1,1, 0,0,  6), // R6 convert at t+2
    mk(12,1,1, 0,0, 0,0, 5,1, 1,1, 0,0,  7), // R7 multiply writes r5
    mk( 4,1,0, 5,1, 0,0, 0,0, 0,0, 0,0,  8), // R8 add on r5 at t+5 too early
    mk( 0,1,0, 5,1, 0,0, 0,0, 1,0, 1,0,  8), // R8 add on r5 at t+6 via bypass
    mk( 2,1,0, 5,1, 0,0, 0,0, 1,1, 0,0,  7), // R7 add on r5 at t+9
    mk(12,1,2, 0,0, 0,0, 7,1, 1,1, 0,0,  7), // R7 convert writes r7
    mk( 3,1,2, 7,1, 0,0, 0,0, 0,0, 0,0,  7), // R7 convert on r7 at t+4
    mk( 0,1,2, 7,1, 0,0, 0,0, 1,1, 0,0,  7), // R7 convert on r7 at t+5
    mk(12,1,0, 0,0, 0,0, 4,1, 1,1, 0,0,  8), // R8 add writes r4
    mk( 2,1,0, 0,0, 4,1, 0,0, 1,0, 2,0,  8), // R8 add on r4 (src B) at t+3
    mk(12,1,1, 0,0, 0,0, 9,1, 1,1, 0,0, 10), // R10 multiply writes r9
    mk( 0,1,0, 9,0, 0,0, 0,0, 1,1, 0,0, 10), // R10 unused source on r9
    mk(12,1,3, 0,0, 0,0, 0,0, 0,0, 0,0,  2), // R2 class 3
    mk( 0,0,0, 0,0, 0,0, 0,0, 0,0, 0,0,  2), // R2 no request
    mk(12,1,1, 0,0, 0,0, 6,1, 1,1, 0,0,  9), // R9 multiply writes r6
    mk( 5,1,2, 6,1, 0,0, 0,0, 0,0, 0,0,  9), // R9 convert on r6 at t+6
    mk(12,1,0, 0,0, 0,0, 3,0, 1,1, 0,0, 10), // R10 add, destination unused
    mk( 0,1,1, 3,1, 0,0, 0,0, 1,1, 0,0, 10)  // R10 multiply on r3 at t+1
  };

  task automatic chk(string tag, logic [1:0] act, logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic idle();
    req_vld = 1'b0; req_cls = 2'd0;
    src_a = '0; src_a_use = 1'b0; src_b = '0; src_b_use = 1'b0;
    dst = '0; dst_use = 1'b0;
  endtask

  task automatic drive(vec_t v);
    req_vld = v.vld; req_cls = v.cls;
    src_a = v.sa; src_a_use = v.sau; src_b = v.sb; src_b_use = v.sbu;
    dst = v.d; dst_use = v.du;
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    idle();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    // R1 outputs low in reset
    chk("R1 reset grant u0", {1'b0, grant0}, 2'd0);
    chk("R1 reset grant u1", {1'b0, grant1}, 2'd0);
    chk("R1 reset byp u0", byp0, 2'd0);
    rst = 1'b0;
    @(negedge clk);
    // R2 idle after reset
    chk("R2 idle grant u0", {1'b0, grant0}, 2'd0);

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = TBL[i];
      repeat (int'(v.gap)) @(negedge clk);
      drive(v);
      @(negedge clk);
      chk($sformatf("R%0d row %0d grant u0", v.req, i), {1'b0, grant0}, {1'b0, v.g0});
      chk($sformatf("R%0d row %0d grant u1", v.req, i), {1'b0, grant1}, {1'b0, v.g1});
      chk($sformatf("R%0d row %0d byp u0", v.req, i), byp0, v.b0);
      chk($sformatf("R%0d row %0d byp u1", v.req, i), byp1, v.b1);
      idle();
    end

    // R1 reset clears the scoreboard and window
    repeat (12) @(negedge clk);
    drive(mk(0,1,1, 0,0, 0,0, 5,1, 0,0, 0,0, 1));
    @(negedge clk);
    chk("R1 producer grant u0", {1'b0, grant0}, 2'd1);
    idle();
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R1 grant in reset u0", {1'b0, grant0}, 2'd0);
    chk("R1 grant in reset u1", {1'b0, grant1}, 2'd0);
    rst = 1'b0;
    drive(mk(0,1,0, 5,1, 0,0, 0,0, 0,0, 0,0, 1));
    @(negedge clk);
    chk("R1 consumer after reset u0", {1'b0, grant0}, 2'd1);
    chk("R1 consumer after reset u1", {1'b0, grant1}, 2'd1);
    chk("R1 no bypass after reset u0", byp0, 2'd0);
    idle();

    done = 1'b1;
    report();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      report();
      $finish;
    end
  end

endmodule